// File: doc/BRIEF.md
# Swizzled Tile Address Generator

This block turns a logical position inside a 64-row by 32-column tile of 16-bit elements into a physical byte address in a banked shared memory. A row holds four column packs of eight elements each, so one pack is 128 bits. A caller presents a row and a column with a qualifying valid bit and a mode bit. One clock later the block returns the byte address, with an output valid that is the input valid delayed by one cycle.

Two placements are offered. The linear mode stores the tile exactly row-major. The swizzled mode keeps every element inside its own row but moves its pack to the slot `pack XOR (row mod 4)`. The tile still takes the same 4 KiB. With that placement, groups of lanes that issue 128-bit stores or 128-bit loads in a matrix-multiply schedule reach 32 different 4-byte banks, so no access has to wait for another. A layering parameter can split each physical row into sub-rows. The resulting byte address does not change with it.

Top module: `swz_addr_gen`

## Requirements
- R1: While reset is asserted, and at the first clock edge after it is released, out_valid is 0 and out_addr is 0.
- R2: out_valid equals the in_valid of the previous clock cycle.
- R3: With swizzle_en = 0, an accepted (row, col) gives out_addr = (row*32 + col)*2 on the next cycle.
- R4: With swizzle_en = 1, an accepted (row, col) gives out_addr = (row*32 + p*8 + col mod 8)*2 on the next cycle, where p = (col / 8) XOR (row mod 4).
- R5: In both modes, out_addr bit 0 is 0, bits [3:1] equal col mod 8, and bits [11:6] equal row. Only the pack field [5:4] depends on the mode.
- R6: A cycle with in_valid = 0 leaves out_addr unchanged, whatever the row, column and mode inputs hold.
- R7: In swizzled mode, the 2048 coordinates of the tile map to 2048 distinct even addresses in 0..4094, so the tile needs no more storage than in linear mode.
- R8: Bank is (addr/4) mod 32, and a 128-bit access covers four consecutive banks. For the store pattern, lane l writes row l/4, pack l mod 4, and lanes are grouped in blocks of eight consecutive lanes. In both modes, no two lanes of a block share a bank.
- R9: For the load pattern, lane l (0..63) reads row l mod 16, pack l/16. Eight groups each join two blocks of four lanes: starting lanes (0,20), (4,16), (8,28), (12,24), (32,52), (36,48), (40,60), (44,56). In swizzled mode, no two lanes of a group share a bank.
- R10: In linear mode the same load pattern shows bank collisions: lanes sharing a bank exist in at least one group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_row, in_col and swizzle_en |
| in_row | input | 6 | Logical row in the tile |
| in_col | input | 5 | Logical column in the tile |
| swizzle_en | input | 1 | 1 selects XOR-swizzled placement, 0 selects linear |
| out_valid | output | 1 | in_valid delayed one cycle |
| out_addr | output | 12 | Physical byte address, held between valid cycles |

## Verification
A wrong XOR key or a wrong pack slice shows up on the very next cycle, in the pack field of out_addr only. The row and element fields stay correct, so a full sweep of the tile against an independent formula exposes it, and so does the duplicate-address check. A flaw that only breaks bank spread, such as a key taken from the wrong row bits, can still give a valid permutation. The bank-collision checks over the store and load lane groups catch such a flaw, one cycle after each lane's coordinate is presented. An address register that is enabled wrongly shows up on the cycle after an idle input.

// File: rtl/swz_pkg.sv
package swz_pkg;

  // Swizzle key: the row reduced modulo the number of packs per row.
  function automatic int unsigned row_key(int unsigned row, int unsigned packs);
    return row % packs;
  endfunction

  // Byte address from a physical (sub-)row, pack within it, and element offset.
  function automatic int unsigned byte_addr(int unsigned phys_row, int unsigned sub_pack,
                                            int unsigned elem, int unsigned sub_cols,
                                            int unsigned pack_elems, int unsigned elem_bytes);
    return (phys_row * sub_cols + sub_pack * pack_elems + elem) * elem_bytes;
  endfunction

endpackage

// File: rtl/swz_coord_split.sv
module swz_coord_split #(
  parameter int unsigned ROW_W = 6,
  parameter int unsigned COL_W = 5,
  parameter int unsigned K1_W  = 3,
  localparam int unsigned PACK_W = COL_W - K1_W
) (
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  output logic [ROW_W-1:0]  m,
  output logic [PACK_W-1:0] k0,
  output logic [K1_W-1:0]   k1
);
  assign m  = row;
  assign k0 = col[COL_W-1:K1_W];
  assign k1 = col[K1_W-1:0];
endmodule

// File: rtl/swz_pack_remap.sv
module swz_pack_remap #(
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned PACK_W = 2,
  parameter int unsigned PACKS  = 4,
  parameter int unsigned LAYERS = 1,
  parameter int unsigned L_W    = 1
) (
  input  logic [ROW_W-1:0]  m,
  input  logic [PACK_W-1:0] k0,
  input  logic              swz,
  output logic [PACK_W-1:0] key,
  output logic [PACK_W-1:0] k0_eff,
  output logic [L_W-1:0]    sub_row,
  output logic [PACK_W-1:0] k0_sub
);
  assign key    = PACK_W'(swz_pkg::row_key(32'(m), PACKS));
  assign k0_eff = swz ? (k0 ^ key) : k0;

  generate
    if (LAYERS == 1) begin : g_flat
      assign sub_row = '0;
      assign k0_sub  = k0_eff;
    end else begin : g_split
      localparam int unsigned PPS = PACKS / LAYERS;
      assign sub_row = L_W'(32'(k0_eff) / PPS);
      assign k0_sub  = PACK_W'(32'(k0_eff) % PPS);
    end
  endgenerate
endmodule

// File: rtl/swz_addr_pack.sv
module swz_addr_pack #(
  parameter int unsigned ROW_W      = 6,
  parameter int unsigned PACK_W     = 2,
  parameter int unsigned K1_W       = 3,
  parameter int unsigned L_W        = 1,
  parameter int unsigned LAYERS     = 1,
  parameter int unsigned SUB_COLS   = 32,
  parameter int unsigned PACK_ELEMS = 8,
  parameter int unsigned ELEM_BYTES = 2,
  parameter int unsigned ADDR_W     = 12
) (
  input  logic [ROW_W-1:0]  m,
  input  logic [L_W-1:0]    sub_row,
  input  logic [PACK_W-1:0] k0_sub,
  input  logic [K1_W-1:0]   k1,
  output logic [ADDR_W-1:0] addr
);
  logic [31:0] phys_row;

  assign phys_row = 32'(m) * LAYERS + 32'(sub_row);
  assign addr = ADDR_W'(swz_pkg::byte_addr(phys_row, 32'(k0_sub), 32'(k1),
                                           SUB_COLS, PACK_ELEMS, ELEM_BYTES));
endmodule

// File: rtl/swz_addr_gen.sv
module swz_addr_gen #(
  parameter int unsigned ROWS       = 64,
  parameter int unsigned COLS       = 32,
  parameter int unsigned PACK_ELEMS = 8,
  parameter int unsigned ELEM_BYTES = 2,
  parameter int unsigned LAYERS     = 1,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned ADDR_W = $clog2(ROWS * COLS * ELEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  input  logic              swizzle_en,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr
);
  localparam int unsigned PACKS    = COLS / PACK_ELEMS;
  localparam int unsigned K1_W     = $clog2(PACK_ELEMS);
  localparam int unsigned PACK_W   = COL_W - K1_W;
  localparam int unsigned L_W      = (LAYERS > 1) ? $clog2(LAYERS) : 1;
  localparam int unsigned SUB_COLS = COLS / LAYERS;

  // Named internal events, visible to the bound checker.
  logic [ROW_W-1:0]  m_w;
  logic [PACK_W-1:0] k0_w;
  logic [K1_W-1:0]   k1_w;
  logic [PACK_W-1:0] key_w;
  logic [PACK_W-1:0] pack_eff_w;
  logic [L_W-1:0]    sub_row_w;
  logic [PACK_W-1:0] sub_pack_w;
  logic [ADDR_W-1:0] addr_next_w;

  swz_coord_split #(.ROW_W(ROW_W), .COL_W(COL_W), .K1_W(K1_W)) u_split (
    .row(in_row), .col(in_col), .m(m_w), .k0(k0_w), .k1(k1_w)
  );

  swz_pack_remap #(
    .ROW_W(ROW_W), .PACK_W(PACK_W), .PACKS(PACKS), .LAYERS(LAYERS), .L_W(L_W)
  ) u_remap (
    .m(m_w), .k0(k0_w), .swz(swizzle_en), .key(key_w), .k0_eff(pack_eff_w),
    .sub_row(sub_row_w), .k0_sub(sub_pack_w)
  );

  swz_addr_pack #(
    .ROW_W(ROW_W), .PACK_W(PACK_W), .K1_W(K1_W), .L_W(L_W), .LAYERS(LAYERS),
    .SUB_COLS(SUB_COLS), .PACK_ELEMS(PACK_ELEMS), .ELEM_BYTES(ELEM_BYTES),
    .ADDR_W(ADDR_W)
  ) u_pack (
    .m(m_w), .sub_row(sub_row_w), .k0_sub(sub_pack_w), .k1(k1_w), .addr(addr_next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_addr <= addr_next_w;
    end
  end
endmodule

// File: rtl/swz_addr_gen_chk.sv
module swz_addr_gen_chk #(
  parameter int unsigned ROWS       = 64,
  parameter int unsigned COLS       = 32,
  parameter int unsigned PACK_ELEMS = 8,
  parameter int unsigned ELEM_BYTES = 2,
  localparam int unsigned ROW_W  = $clog2(ROWS),
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned ADDR_W = $clog2(ROWS * COLS * ELEM_BYTES),
  localparam int unsigned K1_W   = $clog2(PACK_ELEMS),
  localparam int unsigned PACK_W = COL_W - K1_W,
  localparam int unsigned EB_W   = $clog2(ELEM_BYTES),
  localparam int unsigned PK_LO  = EB_W + K1_W,
  localparam int unsigned ROW_LO = PK_LO + PACK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ROW_W-1:0]  in_row,
  input logic [COL_W-1:0]  in_col,
  input logic              swizzle_en,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic [PACK_W-1:0] key_w,
  input logic [PACK_W-1:0] pack_eff_w
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk) $rose(rst_n) |-> (!out_valid && out_addr == '0));
  // R2
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_delay: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  a_r3_linear_pack: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !swizzle_en) |=> out_addr[PK_LO +: PACK_W] == $past(in_col[COL_W-1 -: PACK_W]));
  // R4
  a_r4_swizzle_pack: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && swizzle_en) |=>
      out_addr[PK_LO +: PACK_W] == ($past(in_col[COL_W-1 -: PACK_W]) ^ $past(in_row[PACK_W-1:0])));
  // R5
  a_r5_row_field: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_addr[ROW_LO +: ROW_W] == $past(in_row));
  a_r5_elem_field: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_addr[EB_W +: K1_W] == $past(in_col[K1_W-1:0]));
  // R6
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_addr));
  // R7: the remap can be undone with the same key, so no two packs collide
  a_r7_invertible: assert property (@(posedge clk) disable iff (!rst_n)
    swizzle_en |-> ((pack_eff_w ^ key_w) == in_col[COL_W-1 -: PACK_W]));
endmodule

bind swz_addr_gen swz_addr_gen_chk #(
  .ROWS(ROWS), .COLS(COLS), .PACK_ELEMS(PACK_ELEMS), .ELEM_BYTES(ELEM_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row(in_row), .in_col(in_col),
  .swizzle_en(swizzle_en), .out_valid(out_valid), .out_addr(out_addr),
  .key_w(key_w), .pack_eff_w(pack_eff_w)
);

// File: tb/test_swz_addr_gen.sv
module test_swz_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [5:0]  in_row = '0;
  logic [4:0]  in_col = '0;
  logic        swizzle_en = 1'b0;
  logic        out_valid;
  logic [11:0] out_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;  // 50 MHz

  swz_addr_gen i_swz_addr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row(in_row), .in_col(in_col),
    .swizzle_en(swizzle_en), .out_valid(out_valid), .out_addr(out_addr)
  );

  // Vector: {mode, row[5:0], col[4:0], expected addr[11:0]}
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 6'd0,  5'd0,  12'd0},
    {1'b0, 6'd1,  5'd9,  12'd82},
    {1'b0, 6'd63, 5'd31, 12'd4094},
    {1'b0, 6'd5,  5'd16, 12'd352},
    {1'b1, 6'd0,  5'd0,  12'd0},
    {1'b1, 6'd1,  5'd0,  12'd80},
    {1'b1, 6'd2,  5'd9,  12'd178},
    {1'b1, 6'd3,  5'd31, 12'd206},
    {1'b1, 6'd63, 5'd31, 12'd4046},
    {1'b1, 6'd5,  5'd16, 12'd368},
    {1'b1, 6'd6,  5'd27, 12'd406},
    {1'b0, 6'd6,  5'd27, 12'd438}
  };

  localparam int RG_A [8] = '{0, 4, 8, 12, 32, 36, 40, 44};
  localparam int RG_B [8] = '{20, 16, 28, 24, 52, 48, 60, 56};

  function automatic int model_addr(bit mode, int row, int col);
    int p;
    p = col / 8;
    if (mode) p = p ^ (row % 4);
    return (row * 32 + p * 8 + col % 8) * 2;
  endfunction

  task automatic check(string req, int actual, int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Present one coordinate, return the address one cycle later.
  task automatic lookup(bit mode, int row, int col, output int addr);
    @(negedge clk);
    in_valid = 1'b1; swizzle_en = mode; in_row = 6'(row); in_col = 5'(col);
    @(negedge clk);
    addr = int'(out_addr);
  endtask

  task automatic mark_banks(int addr, ref bit [31:0] used, ref int clashes);
    int b0;
    b0 = (addr / 4) % 32;
    for (int j = 0; j < 4; j++) begin
      if (used[(b0 + j) % 32]) clashes++;
      used[(b0 + j) % 32] = 1'b1;
    end
  endtask

  task automatic store_clashes(bit mode, output int total);
    int a;
    total = 0;
    for (int g = 0; g < 8; g++) begin
      bit [31:0] used = '0;
      for (int l = 8 * g; l < 8 * g + 8; l++) begin
        lookup(mode, l / 4, (l % 4) * 8, a);
        mark_banks(a, used, total);
      end
    end
  endtask

  task automatic load_clashes(bit mode, output int total);
    int a;
    total = 0;
    for (int g = 0; g < 8; g++) begin
      bit [31:0] used = '0;
      for (int k = 0; k < 8; k++) begin
        int l;
        l = (k < 4) ? RG_A[g] + k : RG_B[g] + k - 4;
        lookup(mode, l % 16, (l / 16) * 8, a);
        mark_banks(a, used, total);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int a, b, mism, dup, clash;
    bit seen [4096];

    // R1: reset state, also with in_valid raised during reset
    in_valid = 1'b1; in_row = 6'd7; in_col = 5'd7;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 addr in reset", int'(out_addr), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after release", int'(out_valid), 0);
    check("R1 addr after release", int'(out_addr), 0);

    // R3 R4 R5: vector table
    for (int i = 0; i < NV; i++) begin
      lookup(VEC[i][23], int'(VEC[i][22:17]), int'(VEC[i][16:12]), a);
      check(VEC[i][23] ? "R4 vector" : "R3 vector", a, int'(VEC[i][11:0]));
      check("R5 element field", (a >> 1) % 8, int'(VEC[i][16:12]) % 8);
      check("R2 valid follows", int'(out_valid), 1);
    end

    // R6: idle cycles with changing inputs keep the address
    lookup(1'b1, 9, 13, a);
    @(negedge clk);
    in_valid = 1'b0; in_row = 6'd40; in_col = 5'd3; swizzle_en = 1'b0;
    @(negedge clk);
    check("R2 idle gives no valid", int'(out_valid), 0);
    check("R6 hold after idle", int'(out_addr), model_addr(1'b1, 9, 13));
    swizzle_en = 1'b1; in_row = 6'd63;
    @(negedge clk);
    check("R6 hold second idle", int'(out_addr), model_addr(1'b1, 9, 13));

    // R3 R4 R5 R7: full sweep in both modes
    for (int md = 0; md < 2; md++) begin
      mism = 0; dup = 0;
      for (int i = 0; i < 4096; i++) seen[i] = 1'b0;
      for (int r = 0; r < 64; r++) begin
        for (int c = 0; c < 32; c++) begin
          lookup(md[0], r, c, b);
          if (b != model_addr(md[0], r, c)) mism++;
          if ((b % 2) != 0 || (b >> 6) != r) mism++;
          if (seen[b]) dup++;
          seen[b] = 1'b1;
        end
      end
      check(md ? "R4 sweep mismatches" : "R3 sweep mismatches", mism, 0);
      check("R7 duplicate addresses", dup, 0);
    end

    // R8: stores, both modes
    store_clashes(1'b0, clash);
    check("R8 linear store clashes", clash, 0);
    store_clashes(1'b1, clash);
    check("R8 swizzled store clashes", clash, 0);

    // R9 R10: loads
    load_clashes(1'b1, clash);
    check("R9 swizzled load clashes", clash, 0);
    load_clashes(1'b0, clash);
    check("R10 linear load has clashes", int'(clash > 0), 1);

    @(negedge clk);
    in_valid = 1'b0;
    report();
  end
endmodule